// File: doc/BRIEF.md
# Resettable Output Data Clock Synchronizer

This block derives an output data clock from the converter's sampling clock and presents it as two identical copies, an in-phase lane and a quadrature lane. Several converters in one system can line up their output clocks by receiving a shared alignment pulse. The pulse may arrive at any moment relative to the sampling clock. Its release is brought into the clock domain and counted forward a fixed number of sampling cycles. On that count every device produces the same falling output edge.

The feature stays dormant until an enable bit is set. The mode inputs control behaviour during alignment. In demux mode the output clock runs at half the sampling rate and is parked high while alignment is pending. In non-demux mode it runs at a slower divided rate and keeps toggling throughout. A DDR phase bit and a 2-bit phase field together fix how far the aligning edge sits from the release. An output-enable flag marks when the clocks are valid again.

Top module: `dclk_align`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to its idle state: after that edge both clock outputs read 0, `dclk_oe` reads 1, and no alignment is pending.
- R2: With `sync_en` at 0, `sync_req` has no effect: `dclk_oe` stays at 1 and the output clock keeps its normal toggling.
- R3: `dclk_i` and `dclk_q` carry the same value in every cycle.
- R4: `sync_req` passes through a two-flop synchronizer. When it is high at two successive rising edges A0 and A1, `dclk_oe` reads 0 after edge A2.
- R5: With `demux_mode`=1, the output clock inverts on every sampling edge during normal running. From edge A2 onward it is held at 1 until the aligning edge.
- R6: With `demux_mode`=0, the output clock inverts once every `NDMX_HALF` (default 2) sampling edges, and it keeps doing so while alignment is pending.
- R7: With `phase90`=1 and `phase_sel`=0, the aligning edge is the rising sampling edge 4 cycles after E0, where E0 is the first rising edge at which `sync_req` is seen low after its release.
- R8: With `phase90`=0 and `phase_sel`=0, the aligning edge falls 5 cycles after E0.
- R9: A non-zero `phase_sel`, read as an unsigned value 0..3, delays the aligning edge by that many more sampling cycles.
- R10: At the aligning edge both clock outputs go to 0 and the divider phase restarts. The first rise follows one half period later: 1 cycle in demux mode, `NDMX_HALF` cycles otherwise.
- R11: `dclk_oe` stays at 0 from the R4 point until `OE_DLY` (default 1) sampling edges after the aligning edge, and then returns to 1.
- R12: If `sync_req` is raised again before the aligning edge, the pending count restarts. The aligning edge is then timed from the last release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_req | input | 1 | Alignment pulse, active high, asynchronous |
| sync_en | input | 1 | Enables the alignment feature |
| demux_mode | input | 1 | 1: half-rate clock parked high during alignment; 0: divided clock runs on |
| phase90 | input | 1 | 1: 90° DDR phase (shorter delay); 0: 0° phase |
| phase_sel | input | 2 | Extra aligning-edge delay in cycles |
| dclk_i | output | 1 | In-phase output data clock |
| dclk_q | output | 1 | Quadrature output data clock, same as dclk_i |
| dclk_oe | output | 1 | Output clocks valid |

## Verification
The hardest situation to reach from the ports is a second alignment pulse that lands while the first release is still counting down. The second pulse has to arrive after the release has entered the synchronizer, yet early enough that its own synchronized rise comes before the count can finish. The stimulus uses the longest delay setting, with 0° phase and the largest phase field, and raises the pulse again two cycles after release. It then checks that the aligning edge is timed from the second release. The table-driven part sweeps the mode, phase and phase-field combinations and samples the cycle just before, at and after each expected aligning edge.

// File: rtl/dclk_align_pkg.sv
// Package: shared types and helpers for the output data clock aligner.
// Assumes: nothing beyond IEEE 1800-2017.
package dclk_align_pkg;

    // Alignment state: free running, or waiting for the aligning edge.
    typedef enum logic {
        ST_RUN = 1'b0,
        ST_ARM = 1'b1
    } align_state_t;

    // Larger of two integers, used to size counters.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dclk_sync2.sv
// Module: multi-stage synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; the input may change at any time relative to clk.
module dclk_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] pipe;

    // Shift the level through the flop chain; cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], d};
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/dclk_release_timer.sv
// Module: tracks a pending alignment and times the aligning edge.
// Counting starts on the first edge that sees the synchronized request low.
// The aligning edge fires when the count reaches the base delay minus two
// (the two synchronizer stages) plus the phase field.
// Assumes: DLY_90 >= 2 and DLY_0 >= 2.
module dclk_release_timer
    import dclk_align_pkg::*;
#(
    parameter int DLY_90 = 4,
    parameter int DLY_0  = 5,
    parameter int PSEL_W = 2,
    parameter int OE_DLY = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_act,
    input  logic              phase90,
    input  logic [PSEL_W-1:0] phase_sel,
    output align_state_t      state_o,
    output logic              sync_o,
    output logic              oe_o
);

    localparam int DLY_MAX = max2(DLY_90, DLY_0) + (1 << PSEL_W);
    localparam int DLY_W   = $clog2(DLY_MAX + 1);
    localparam int OW      = $clog2(OE_DLY + 2);
    localparam logic [DLY_W-1:0] BASE90  = DLY_W'(DLY_90 - 2);
    localparam logic [DLY_W-1:0] BASE0   = DLY_W'(DLY_0 - 2);
    localparam logic [OW-1:0]    OE_INIT = OW'(OE_DLY);

    align_state_t     state;
    logic [DLY_W-1:0] dly;
    logic [DLY_W-1:0] target;
    logic [OW-1:0]    oe_wait;

    // Count value at which the aligning edge fires.
    always_comb begin
        target = (phase90 ? BASE90 : BASE0) + DLY_W'(phase_sel);
    end

    // Aligning edge happens on this clock edge.
    assign sync_o = (state == ST_ARM) && !req_act && (dly >= target);

    // State, release count and output-enable wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_RUN;
            dly     <= '0;
            oe_wait <= '0;
        end else begin
            if (oe_wait != '0) begin
                oe_wait <= oe_wait - 1'b1;
            end
            case (state)
                ST_RUN: begin
                    if (req_act) begin
                        state <= ST_ARM;
                        dly   <= '0;
                    end
                end
                ST_ARM: begin
                    if (req_act) begin
                        dly <= '0;
                    end else if (dly >= target) begin
                        state   <= ST_RUN;
                        oe_wait <= OE_INIT;
                    end else begin
                        dly <= dly + 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    assign state_o = state;
    assign oe_o    = (state == ST_RUN) && (oe_wait == '0);

endmodule

// File: rtl/dclk_divider.sv
// Module: one lane of the output clock divider.
// Demux mode inverts every cycle and parks high on request.
// Non-demux mode inverts every NDMX_HALF cycles.
// The aligning pulse forces the clock low and restarts its phase.
// Assumes: NDMX_HALF >= 1.
module dclk_divider #(
    parameter int NDMX_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic demux_mode,
    input  logic hold,
    input  logic sync,
    output logic dclk
);

    localparam int CW = $clog2(NDMX_HALF + 1);
    localparam logic [CW-1:0] NDMX_LIM = CW'(NDMX_HALF - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Half-period limit for the current mode.
    always_comb begin
        lim = demux_mode ? '0 : NDMX_LIM;
    end

    // Clock register with align, park and divide priorities.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dclk <= 1'b0;
            cnt  <= '0;
        end else if (sync) begin
            dclk <= 1'b0;
            cnt  <= '0;
        end else if (demux_mode && hold) begin
            dclk <= 1'b1;
            cnt  <= '0;
        end else if (cnt >= lim) begin
            dclk <= ~dclk;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dclk_align.sv
// Module: top of the output data clock aligner.
// Synchronizes the alignment pulse, gates it with the enable, times the
// aligning edge and drives two identical divider lanes.
// Assumes: a single sampling clock domain; synchronous active-low reset.
module dclk_align
    import dclk_align_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DLY_90      = 4,
    parameter int DLY_0       = 5,
    parameter int OE_DLY      = 1,
    parameter int NDMX_HALF   = 2,
    parameter int PSEL_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_req,
    input  logic              sync_en,
    input  logic              demux_mode,
    input  logic              phase90,
    input  logic [PSEL_W-1:0] phase_sel,
    output logic              dclk_i,
    output logic              dclk_q,
    output logic              dclk_oe
);

    localparam int NUM_LANES = 2;

    logic                 req_s;
    logic                 req_act;
    align_state_t         state_w;
    logic                 arm_w;
    logic                 sync_w;
    logic                 hold_w;
    logic [NUM_LANES-1:0] lane_clk;

    // Bring the asynchronous pulse into the clock domain.
    dclk_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_req),
        .q     (req_s)
    );

    // Request counts only while the feature is enabled.
    assign req_act = req_s & sync_en;

    dclk_release_timer #(
        .DLY_90 (DLY_90),
        .DLY_0  (DLY_0),
        .PSEL_W (PSEL_W),
        .OE_DLY (OE_DLY)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_act   (req_act),
        .phase90   (phase90),
        .phase_sel (phase_sel),
        .state_o   (state_w),
        .sync_o    (sync_w),
        .oe_o      (dclk_oe)
    );

    assign arm_w  = (state_w == ST_ARM);
    assign hold_w = arm_w | req_act;

    // One divider per output lane, all driven by the same controls.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        dclk_divider #(.NDMX_HALF(NDMX_HALF)) u_div (
            .clk        (clk),
            .rst_n      (rst_n),
            .demux_mode (demux_mode),
            .hold       (hold_w),
            .sync       (sync_w),
            .dclk       (lane_clk[g])
        );
    end

    assign dclk_i = lane_clk[0];
    assign dclk_q = lane_clk[1];

endmodule

// File: rtl/dclk_align_chk.sv
// Checker: temporal properties of the aligner, bound to the top module.
// Assumes: default parameters for the output-enable relation.
module dclk_align_chk (
    input logic clk,
    input logic rst_n,
    input logic sync_en,
    input logic demux_mode,
    input logic req_act,
    input logic hold_w,
    input logic sync_w,
    input logic dclk_i,
    input logic dclk_q,
    input logic dclk_oe
);

    logic past_ok;

    // Marks that one cycle out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R3: the two lanes never differ.
    p_lanes_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_i == dclk_q);

    // R2: with the feature disabled, a valid output stays valid.
    p_disabled_keeps_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_en && dclk_oe) |=> dclk_oe);

    // R4: a synchronized request drops the output enable.
    p_req_drops_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(req_act)) |-> !dclk_oe);

    // R5: demux mode parks the clock high while alignment is pending.
    p_demux_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(demux_mode) && $past(hold_w) && !$past(sync_w)) |-> dclk_i);

    // R5: demux mode inverts the clock every cycle when running.
    p_demux_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(demux_mode) && !$past(hold_w) && !$past(sync_w))
            |-> (dclk_i != $past(dclk_i)));

    // R10: the aligning edge drives both lanes low.
    p_sync_falls_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_w |=> (!dclk_i && !dclk_q));

endmodule

bind dclk_align dclk_align_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_en    (sync_en),
    .demux_mode (demux_mode),
    .req_act    (req_act),
    .hold_w     (hold_w),
    .sync_w     (sync_w),
    .dclk_i     (dclk_i),
    .dclk_q     (dclk_q),
    .dclk_oe    (dclk_oe)
);

// File: tb/dclk_align_tb.sv
// Bench: table of mode vectors followed by directed reset and corner tests.
module dclk_align_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sync_req;
    logic       sync_en;
    logic       demux_mode;
    logic       phase90;
    logic [1:0] phase_sel;
    logic       dclk_i;
    logic       dclk_q;
    logic       dclk_oe;

    int errors = 0;
    int checks = 0;

    // Each entry: {demux, phase90, phase_sel[1:0], ticks_to_fall[3:0]}.
    // ticks_to_fall = base delay (4 or 5) + phase_sel + 1 negedge samples.
    localparam logic [7:0] VEC [6] = '{
        {1'b1, 1'b1, 2'd0, 4'd5},
        {1'b1, 1'b0, 2'd0, 4'd6},
        {1'b1, 1'b1, 2'd2, 4'd7},
        {1'b1, 1'b0, 2'd3, 4'd9},
        {1'b0, 1'b1, 2'd0, 4'd5},
        {1'b0, 1'b0, 2'd1, 4'd7}
    };

    always #10 clk = ~clk;

    dclk_align u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_req   (sync_req),
        .sync_en    (sync_en),
        .demux_mode (demux_mode),
        .phase90    (phase90),
        .phase_sel  (phase_sel),
        .dclk_i     (dclk_i),
        .dclk_q     (dclk_q),
        .dclk_oe    (dclk_oe)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic prev;
        int   toggles;
        logic dm, p9;
        logic [1:0] ps;
        logic [3:0] ex;
        string edge_tag;

        rst_n      = 1'b0;
        sync_req   = 1'b0;
        sync_en    = 1'b0;
        demux_mode = 1'b1;
        phase90    = 1'b1;
        phase_sel  = 2'd0;
        repeat (3) tick();

        // R1: idle values during reset.
        chk(dclk_i == 1'b0, "R1 dclk_i", dclk_i, 0);
        chk(dclk_q == 1'b0, "R1 dclk_q", dclk_q, 0);
        chk(dclk_oe == 1'b1, "R1 oe", dclk_oe, 1);
        rst_n = 1'b1;

        // R5: demux free run inverts every cycle.
        tick();
        prev = dclk_i;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk(dclk_i == !prev, "R5 free run toggle", dclk_i, !prev);
            prev = dclk_i;
        end

        // R2: request ignored while disabled.
        sync_req = 1'b1;
        for (int k = 0; k < 6; k++) begin
            tick();
            chk(dclk_oe == 1'b1, "R2 oe kept", dclk_oe, 1);
            chk(dclk_i == !prev, "R2 clock runs", dclk_i, !prev);
            prev = dclk_i;
        end
        sync_req = 1'b0;
        sync_en  = 1'b1;
        repeat (3) tick();

        // Table walk over modes and phase settings.
        for (int v = 0; v < 6; v++) begin
            {dm, p9, ps, ex} = VEC[v];
            demux_mode = dm;
            phase90    = p9;
            phase_sel  = ps;
            edge_tag   = (ps != 0) ? "R9 aligning edge" : (p9 ? "R7 aligning edge" : "R8 aligning edge");
            repeat (3) tick();
            sync_req = 1'b1;
            repeat (3) tick();
            chk(dclk_oe == 1'b0, "R4 oe drop", dclk_oe, 0);
            if (dm) chk(dclk_i == 1'b1, "R5 parked high", dclk_i, 1);
            prev    = dclk_i;
            toggles = 0;
            for (int k = 0; k < 4; k++) begin
                tick();
                if (dclk_i != prev) toggles++;
                prev = dclk_i;
            end
            if (dm) chk(toggles == 0 && dclk_i, "R5 stays parked", toggles, 0);
            else    chk(toggles == 2, "R6 runs during alignment", toggles, 2);
            sync_req = 1'b0;
            for (int t = 1; t <= int'(ex) + 2; t++) begin
                tick();
                chk(dclk_i == dclk_q, "R3 lanes equal", dclk_q, dclk_i);
                if (t == int'(ex) - 1) begin
                    chk(dclk_oe == 1'b0, "R11 oe low before edge", dclk_oe, 0);
                    if (dm) chk(dclk_i == 1'b1, "R5 high before edge", dclk_i, 1);
                end
                if (t == int'(ex)) begin
                    chk(dclk_i == 1'b0, edge_tag, dclk_i, 0);
                    chk(dclk_oe == 1'b0, "R11 oe low at edge", dclk_oe, 0);
                end
                if (t == int'(ex) + 1) begin
                    chk(dclk_oe == 1'b1, "R11 oe back", dclk_oe, 1);
                    chk(dclk_i == dm, "R10 first half period", dclk_i, dm);
                end
                if (t == int'(ex) + 2) begin
                    chk(dclk_i == !dm, "R10 R6 second half period", dclk_i, !dm);
                end
            end
        end

        // R12: re-raised request restarts the count.
        demux_mode = 1'b1;
        phase90    = 1'b0;
        phase_sel  = 2'd3;
        repeat (3) tick();
        sync_req = 1'b1;
        repeat (4) tick();
        sync_req = 1'b0;
        repeat (2) tick();
        sync_req = 1'b1;
        repeat (5) tick();
        chk(dclk_oe == 1'b0, "R12 oe held low", dclk_oe, 0);
        chk(dclk_i == 1'b1, "R12 clock parked", dclk_i, 1);
        sync_req = 1'b0;
        for (int t = 1; t <= 10; t++) begin
            tick();
            if (t == 8) chk(dclk_i == 1'b1, "R12 still parked", dclk_i, 1);
            if (t == 9) chk(dclk_i == 1'b0, "R12 edge from last release", dclk_i, 0);
            if (t == 10) chk(dclk_oe == 1'b1, "R12 oe back", dclk_oe, 1);
        end

        finish_run();
    end

endmodule